// File: doc/BRIEF.md
# Four-Way Compressed-Test Memory Wrapper

This block wraps a small register-built memory whose data path is four lines wide. Behind every data line sit four sub-blocks of equal depth. It accepts memory cycles that have already been decoded. Each cycle carries a kind, a row address, a column address and four bits of write data. The block returns four bits of read data one clock later.

In normal operation the two lowest column bits pick one sub-block for each line, so the wrapper acts as an ordinary memory that is four bits wide. A special entry cycle switches the wrapper into a compressed test mode. In that mode a write copies each line's bit into all four of that line's sub-blocks at once. A read reports, line by line, whether those four stored copies agree. One access therefore checks four locations. This cuts the time to run a full test pattern to a quarter.

Leaving test mode takes one of the three refresh cycle kinds. Reads and repeated entry cycles issued during test mode keep the wrapper in test mode.

Top module: `quad_cmp_mem`

## Requirements
- R1: After reset, test_mode, rd_valid and rdata are all 0, and every stored bit is 0.
- R2: A valid cycle of kind 5 (WCBR) whose row address bits 0 to 11 are all 1 sets test_mode from the next clock on. The column address and write data of that cycle have no effect.
- R3: A kind-5 cycle with any of row bits 0 to 11 at 0 leaves test_mode and the stored data unchanged.
- R4: A valid cycle of kind 2 (CAS-before-RAS refresh), kind 3 (RAS-only refresh) or kind 4 (hidden refresh) clears test_mode from the next clock on. It has no effect in normal mode, and refresh cycles never change stored data.
- R5: While test_mode is 1, a read cycle (kind 0) or a further qualifying kind-5 cycle leaves test_mode at 1.
- R6: In normal mode a write (kind 1) stores wdata[i] into sub-block col_addr[1:0] of line i, at word {row_addr[1:0], col_addr[3:2]}. The other three sub-blocks of that word keep their contents.
- R7: In normal mode a read (kind 0) returns, on rdata[i], sub-block col_addr[1:0] of line i at the addressed word. The value appears one clock after the cycle, with rd_valid at 1 for exactly that clock.
- R8: In test mode a write stores wdata[i] into all four sub-blocks of line i at the addressed word. col_addr[1:0] is ignored.
- R9: In test mode a read returns rdata[i] = 1 when the four stored copies of line i at the addressed word are equal, and 0 otherwise. Timing is the same as in R7.
- R10: When no read is issued, rd_valid is 0 and rdata keeps its last value. Kinds 6 and 7, and any cycle with cyc_valid at 0, change neither the mode nor the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A cycle is presented this clock |
| cyc_type | input | 3 | Cycle kind: 0 read, 1 write, 2 CBR refresh, 3 RAS-only refresh, 4 hidden refresh, 5 WCBR |
| row_addr | input | 12 | Row address |
| col_addr | input | 4 | Column address; bits 1:0 select the sub-block |
| wdata | input | 4 | Write data, one bit per line |
| rdata | output | 4 | Read data, or the per-line agreement flag in test mode |
| rd_valid | output | 1 | rdata was updated by the previous cycle |
| test_mode | output | 1 | 1 while compressed test mode is active |

## Verification
The bench writes a word whose four sub-blocks hold different patterns, so that a test-mode read gives a mix of 1 and 0 flags. A design that selected one sub-block instead of comparing all four would return stored data there. An entry cycle with a single row bit low must be refused, and a design that decoded only part of the row would enter test mode on it. Each of the three exit kinds is tried on its own, and so are reads and repeated entry cycles in test mode, which would reveal a mode register that clears on any refresh-like cycle. After a test-mode write, the bench reads every sub-block back in normal mode. A design that wrote only the selected sub-block fails that readback.

// File: rtl/qcm_pkg.sv
package qcm_pkg;

  typedef enum logic [2:0] {
    CYC_READ   = 3'd0,
    CYC_WRITE  = 3'd1,
    CYC_CBR    = 3'd2,
    CYC_RONLY  = 3'd3,
    CYC_HIDDEN = 3'd4,
    CYC_WCBR   = 3'd5
  } cyc_kind_e;

  localparam int SUBS = 4;

  // one-hot lane mask for the sub-block picked by the low column bits
  function automatic logic [SUBS-1:0] sub_onehot(input logic [1:0] sel);
    return SUBS'(1) << sel;
  endfunction

  // 1 when all stored copies carry the same value
  function automatic logic copies_agree(input logic [SUBS-1:0] c);
    return (c == '0) || (c == '1);
  endfunction

  // write mask: all four copies in test mode, the selected one otherwise
  function automatic logic [SUBS-1:0] write_mask(input logic tm, input logic [1:0] sel);
    return tm ? '1 : sub_onehot(sel);
  endfunction

endpackage

// File: rtl/qcm_decode.sv
module qcm_decode
  import qcm_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int ENTRY_BITS = 12
) (
  input  logic             cyc_valid,
  input  logic [2:0]       cyc_type,
  input  logic [ROW_W-1:0] row_addr,
  output logic             rd_evt,
  output logic             wr_evt,
  output logic             entry_evt,
  output logic             exit_evt
);

  logic row_all_high;
  assign row_all_high = &row_addr[ENTRY_BITS-1:0];

  always_comb begin
    rd_evt    = 1'b0;
    wr_evt    = 1'b0;
    entry_evt = 1'b0;
    exit_evt  = 1'b0;
    if (cyc_valid) begin
      case (cyc_type)
        CYC_READ:   rd_evt    = 1'b1;
        CYC_WRITE:  wr_evt    = 1'b1;
        CYC_CBR,
        CYC_RONLY,
        CYC_HIDDEN: exit_evt  = 1'b1;
        CYC_WCBR:   entry_evt = row_all_high;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/qcm_mode.sv
module qcm_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic entry_evt,
  input  logic exit_evt,
  output logic test_mode
);

  always_ff @(posedge clk) begin
    if (!rst_n)         test_mode <= 1'b0;
    else if (exit_evt)  test_mode <= 1'b0;
    else if (entry_evt) test_mode <= 1'b1;
  end

endmodule

// File: rtl/qcm_lane.sv
module qcm_lane
  import qcm_pkg::*;
#(
  parameter int WORD_W = 4,
  localparam int WORDS = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic              test_mode,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        sub_sel,
  input  logic              wbit,
  output logic              rbit
);

  logic [SUBS-1:0] store [WORDS];
  logic [SUBS-1:0] wmask;
  logic [SUBS-1:0] copies;
  logic            rbit_next;

  assign wmask     = write_mask(test_mode, sub_sel);
  assign copies    = store[word];
  assign rbit_next = test_mode ? copies_agree(copies) : copies[sub_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (wr_evt) begin
      for (int b = 0; b < SUBS; b++)
        if (wmask[b]) store[word][b] <= wbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rbit <= 1'b0;
    else if (rd_evt) rbit <= rbit_next;
  end

endmodule

// File: rtl/quad_cmp_mem.sv
module quad_cmp_mem
  import qcm_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 4,
  parameter int ROW_USED   = 2,
  parameter int ENTRY_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [2:0]        cyc_type,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              test_mode
);

  localparam int WORD_W = ROW_USED + COL_W - 2;

  logic              rd_evt;
  logic              wr_evt;
  logic              entry_evt;
  logic              exit_evt;
  logic [WORD_W-1:0] word;
  logic [1:0]        sub_sel;

  assign word    = {row_addr[ROW_USED-1:0], col_addr[COL_W-1:2]};
  assign sub_sel = col_addr[1:0];

  qcm_decode #(.ROW_W(ROW_W), .ENTRY_BITS(ENTRY_BITS)) u_decode (
    .cyc_valid (cyc_valid),
    .cyc_type  (cyc_type),
    .row_addr  (row_addr),
    .rd_evt    (rd_evt),
    .wr_evt    (wr_evt),
    .entry_evt (entry_evt),
    .exit_evt  (exit_evt)
  );

  qcm_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_evt (entry_evt),
    .exit_evt  (exit_evt),
    .test_mode (test_mode)
  );

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    qcm_lane #(.WORD_W(WORD_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_evt    (wr_evt),
      .rd_evt    (rd_evt),
      .test_mode (test_mode),
      .word      (word),
      .sub_sel   (sub_sel),
      .wbit      (wdata[g]),
      .rbit      (rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_evt;
  end

endmodule

// File: rtl/qcm_checker.sv
module qcm_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_valid,
  input logic [2:0]        cyc_type,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic              entry_evt,
  input logic              exit_evt,
  input logic              test_mode,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rdata
);

  a_r2_entry_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> test_mode);

  a_r4_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !test_mode);

  a_r3_mode_holds_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_evt && !exit_evt) |=> $stable(test_mode));

  a_r5_read_keeps_test: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && cyc_valid && cyc_type == 3'd0) |=> test_mode);

  a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rd_valid);

  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> !rd_valid);

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rdata));

  always_comb begin
    if (rst_n) a_r10_events_exclusive: assert ($onehot0({rd_evt, wr_evt, entry_evt, exit_evt}));
  end

endmodule

bind quad_cmp_mem qcm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_valid (cyc_valid),
  .cyc_type  (cyc_type),
  .rd_evt    (rd_evt),
  .wr_evt    (wr_evt),
  .entry_evt (entry_evt),
  .exit_evt  (exit_evt),
  .test_mode (test_mode),
  .rd_valid  (rd_valid),
  .rdata     (rdata)
);

// File: tb/quad_cmp_mem_bench.sv
`timescale 1ns/1ps
module quad_cmp_mem_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [2:0]  cyc_type = 3'd0;
  logic [11:0] row_addr = '0;
  logic [3:0]  col_addr = '0;
  logic [3:0]  wdata = '0;
  logic [3:0]  rdata;
  logic        rd_valid;
  logic        test_mode;

  int n_tests = 0;
  int n_fail  = 0;

  bit          mdl [4][4][16];
  bit          mdl_tm = 1'b0;
  logic [3:0]  exp_q[$];
  string       tag_q[$];
  logic [3:0]  last_exp = '0;

  always #10 clk = ~clk;

  quad_cmp_mem u_quad_cmp_mem (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .row_addr(row_addr), .col_addr(col_addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .test_mode(test_mode)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // driver: one cycle, model updated from the requirements
  task automatic cyc(input logic [2:0] t, input logic [11:0] r, input logic [3:0] c,
                     input logic [3:0] d, input string req);
    int w;
    logic [3:0] e;
    w = {r[1:0], c[3:2]};
    @(negedge clk);
    cyc_valid = 1'b1; cyc_type = t; row_addr = r; col_addr = c; wdata = d;
    case (t)
      3'd0: begin
        for (int i = 0; i < 4; i++) begin
          if (mdl_tm) e[i] = (mdl[i][0][w] == mdl[i][1][w]) && (mdl[i][1][w] == mdl[i][2][w])
                             && (mdl[i][2][w] == mdl[i][3][w]);
          else        e[i] = mdl[i][c[1:0]][w];
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
        last_exp = e;
      end
      3'd1: begin
        for (int i = 0; i < 4; i++)
          for (int s = 0; s < 4; s++)
            if (mdl_tm || s == int'(c[1:0])) mdl[i][s][w] = d[i];
      end
      3'd2, 3'd3, 3'd4: mdl_tm = 1'b0;
      3'd5: if (&r) mdl_tm = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever read data is flagged
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rd_valid", 4'h1, 4'h0);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 test_mode", {3'b0, test_mode}, 4'h0);
    chk("R1 rd_valid",  {3'b0, rd_valid},  4'h0);
    chk("R1 rdata",     rdata,             4'h0);
    cyc(3'd0, 12'h001, 4'b1000, 4'h0, "R1 array cleared");

    // R6/R7: distinct patterns into the four sub-blocks of one word
    cyc(3'd1, 12'h001, 4'b1000, 4'h5, "R6");
    cyc(3'd1, 12'h001, 4'b1001, 4'h3, "R6");
    cyc(3'd1, 12'h001, 4'b1010, 4'hF, "R6");
    cyc(3'd1, 12'h001, 4'b1011, 4'h9, "R6");
    cyc(3'd0, 12'h001, 4'b1000, 4'h0, "R7 sub0");
    cyc(3'd0, 12'h001, 4'b1001, 4'h0, "R7 sub1");
    cyc(3'd0, 12'h001, 4'b1010, 4'h0, "R7 sub2");
    cyc(3'd0, 12'h001, 4'b1011, 4'h0, "R6 R7 sub3");

    // R3: entry refused with one row bit low
    cyc(3'd5, 12'hFFE, 4'h0, 4'hA, "R3");
    chk("R3 mode kept", {3'b0, test_mode}, 4'h0);
    cyc(3'd5, 12'h7FF, 4'h0, 4'hA, "R3");
    chk("R3 mode kept msb", {3'b0, test_mode}, 4'h0);
    cyc(3'd0, 12'h001, 4'b1001, 4'h0, "R3 data kept");

    // R2: entry with arbitrary column and data
    cyc(3'd5, 12'hFFF, 4'h7, 4'h6, "R2");
    chk("R2 entered", {3'b0, test_mode}, 4'h1);
    cyc(3'd0, 12'h001, 4'b1010, 4'h0, "R9 mixed agreement");
    cyc(3'd0, 12'h002, 4'b0100, 4'h0, "R9 fresh word agrees");
    chk("R5 read keeps mode", {3'b0, test_mode}, 4'h1);
    cyc(3'd1, 12'h001, 4'b1001, 4'hA, "R8");
    cyc(3'd0, 12'h001, 4'b1011, 4'h0, "R8 R9 after copy write");
    cyc(3'd5, 12'hFFF, 4'h0, 4'h0, "R5");
    chk("R5 repeat entry keeps mode", {3'b0, test_mode}, 4'h1);

    // R4: CBR exit, then readback of every copy
    cyc(3'd2, 12'h000, 4'h0, 4'h0, "R4");
    chk("R4 CBR exit", {3'b0, test_mode}, 4'h0);
    for (int s = 0; s < 4; s++)
      cyc(3'd0, 12'h001, {2'b10, 2'(s)}, 4'h0, "R8 copy readback");

    cyc(3'd5, 12'hFFF, 4'h0, 4'h0, "R2");
    cyc(3'd3, 12'h123, 4'h0, 4'h0, "R4");
    chk("R4 RAS-only exit", {3'b0, test_mode}, 4'h0);
    cyc(3'd5, 12'hFFF, 4'h0, 4'h0, "R2");
    cyc(3'd4, 12'h000, 4'h0, 4'h0, "R4");
    chk("R4 hidden exit", {3'b0, test_mode}, 4'h0);
    cyc(3'd2, 12'h001, 4'b1000, 4'h0, "R4");
    chk("R4 refresh in normal mode", {3'b0, test_mode}, 4'h0);
    cyc(3'd0, 12'h001, 4'b1000, 4'h0, "R4 refresh keeps data");

    // R10: unused kinds and idle cycles
    cyc(3'd6, 12'hFFF, 4'b1000, 4'hF, "R10");
    cyc(3'd7, 12'hFFF, 4'b1000, 4'hF, "R10");
    chk("R10 unused kinds keep mode", {3'b0, test_mode}, 4'h0);
    @(negedge clk);
    cyc_type = 3'd1; row_addr = 12'h001; col_addr = 4'b1000; wdata = 4'h0;
    @(negedge clk);
    cyc_type = 3'd5; row_addr = 12'hFFF;
    @(negedge clk);
    chk("R10 invalid cycle keeps mode", {3'b0, test_mode}, 4'h0);
    cyc(3'd0, 12'h001, 4'b1000, 4'h0, "R10 data kept");
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", rdata, last_exp);
    chk("R10 rd_valid low", {3'b0, rd_valid}, 4'h0);

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", 4'(exp_q.size()), 4'h0);
    summary();
  end

endmodule